// File: doc/BRIEF.md
# UART special character detector

This block sits beside a UART receiver and inspects every character the receiver delivers. It holds four programmable comparison values and reports which of them matched the incoming character. Each hit is recorded as a sticky flag, and a sticky interrupt request is raised for the interrupt controller. The block does not contain the receiver, and it does not contain the logic that pauses the transmitter.

The block's behaviour depends on the active framing mode. In 9-bit framing, all nine bits of a received word are compared against all four slots. In enhanced compatible mode (8-bit framing), only two slots are in use. Slot 2 acts as the XOFF character when in-band receive flow control is selected. Slot 3 acts as a second XOFF character when its own enable is set. Both enhanced comparisons use only the low eight bits. In the alternative (750-style) compatible mode and in plain mode, nothing is detected. Whenever slot 2 matches in enhanced mode with in-band flow control on, a one-cycle XOFF pulse goes to the transmitter flow control.

The mode inputs are decoded into one of four detection modes. Priority runs from the highest: DM_NINE when `mode_nine` is high, DM_ALT750 when `mode_alt750` is high, DM_ENH when `mode_enh` is high, and DM_NONE otherwise. The interrupt request comes from a two-state machine. IRQ_IDLE moves to IRQ_PEND on a qualified match. IRQ_PEND returns to IRQ_IDLE on a status clear, but only when no qualified match arrives in the same cycle. In every other case the machine holds its state.

Top module: `spchr_detect`

## Requirements
- R1: After reset, `match_flags`, `spc_irq` and `xoff_det` are 0 and all four comparison slots hold 0, so a received 9-bit word of 0 in 9-bit mode matches every slot.
- R2: In 9-bit mode, a strobed word equal in all nine bits to slot i sets `match_flags[i]` one cycle after the strobe. A word that differs only in bit 8 does not match.
- R3: In 9-bit mode, a match raises `spc_irq` one cycle after the strobe only when `spc_int_en` is 1. With it at 0, the flags are still set but `spc_irq` stays low. `spc_irq` is never high while all flags are 0.
- R4: In enhanced mode with `spc_int_en` at 0, no flag is set and `spc_irq` does not change.
- R5: In enhanced mode with `spc_int_en` at 1, a character whose bits 7:0 equal bits 7:0 of slot 2 sets `match_flags[2]` and `spc_irq`, whatever its bit 8 is. This happens only while `flow_rx_sel` is not 00. Flags 0 and 1 are never set in enhanced mode.
- R6: In enhanced mode with `spc_int_en` at 1, a match on bits 7:0 of slot 3 sets `match_flags[3]` and `spc_irq` only when `xoff2_en` is 1.
- R7: In alternative (750-style) mode without 9-bit framing, no flag, no interrupt and no XOFF pulse results, whatever `spc_int_en` is.
- R8: `xoff_det` is high for exactly the one cycle after a strobe whose bits 7:0 match slot 2, in enhanced mode with `flow_rx_sel` not 00. This holds whether `spc_int_en` is 0 or 1.
- R9: Flags and `spc_irq` hold until `stat_clr`, which clears both one cycle later. A match in the same cycle as `stat_clr` wins and leaves its flag and the request set.
- R10: After a clear, a new qualified match raises `spc_irq` again.
- R11: Slots can be written at any time through `cfg_wr_*`. A write in the same cycle as a strobe is compared with the old value, and the new value applies from the next character.
- R12: In plain mode (none of the three mode inputs set), no flag, no interrupt and no XOFF pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Write strobe for a comparison slot |
| cfg_wr_idx | input | 2 | Slot to write |
| cfg_wr_data | input | 9 | Value written to the slot |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | 9 | Received character; bit 8 is the address bit in 9-bit framing |
| mode_nine | input | 1 | 9-bit framing mode |
| mode_alt750 | input | 1 | Alternative (750-style) compatible mode |
| mode_enh | input | 1 | Enhanced compatible mode |
| flow_rx_sel | input | 2 | Receive in-band flow-control select; non-zero enables XOFF detection |
| xoff2_en | input | 1 | Enables second XOFF character detection (slot 3) |
| spc_int_en | input | 1 | Special-character enable |
| stat_clr | input | 1 | Status-read pulse; clears flags and request |
| match_flags | output | 4 | Sticky hit flag per slot |
| xoff_det | output | 1 | One-cycle XOFF-detected pulse |
| spc_irq | output | 1 | Sticky special-character interrupt request |

## Verification
The hardest cases to reach are collisions in a single cycle. One is a status clear that coincides with a fresh match. The other is a slot rewrite that coincides with a strobe. Both depend on which value wins at one clock edge. The driver can place a strobe, a clear and a slot write in the same cycle. The scoreboard model applies the old slot contents and the "set beats clear" rule, so the outcome of each collision is predicted independently. Mode changes are applied at the same edge as the next character, so each character is judged under exactly one mode.

// File: rtl/spchr_pkg.sv
package spchr_pkg;

    typedef enum logic [1:0] {
        DM_NONE,
        DM_NINE,
        DM_ENH,
        DM_ALT750
    } det_mode_e;

    typedef enum logic {
        IRQ_IDLE,
        IRQ_PEND
    } irq_st_e;

    // 9-bit framing outranks the alternative mode, which outranks enhanced
    function automatic det_mode_e decode_mode(input logic nine,
                                              input logic alt750,
                                              input logic enh);
        det_mode_e m;
        if (nine)        m = DM_NINE;
        else if (alt750) m = DM_ALT750;
        else if (enh)    m = DM_ENH;
        else             m = DM_NONE;
        return m;
    endfunction

endpackage

// File: rtl/spchr_regs.sv
module spchr_regs #(
    parameter int CHR_W   = 9,
    parameter int NUM_CHR = 4,
    localparam int IDX_W  = (NUM_CHR > 1) ? $clog2(NUM_CHR) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [CHR_W-1:0]                wr_data,
    output logic [NUM_CHR-1:0][CHR_W-1:0]   slot_q
);

    for (genvar i = 0; i < NUM_CHR; i++) begin : g_slot
        logic [CHR_W-1:0] val_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                val_q <= wr_data;
            end
        end

        assign slot_q[i] = val_q;
    end

endmodule

// File: rtl/spchr_match.sv
module spchr_match
    import spchr_pkg::*;
#(
    parameter int CHR_W     = 9,
    parameter int NUM_CHR   = 4,
    parameter int XOFF1_IDX = 2,
    parameter int XOFF2_IDX = 3,
    localparam int LOW_W    = CHR_W - 1
) (
    input  det_mode_e                       mode,
    input  logic                            spc_en,
    input  logic [1:0]                      flow_rx_sel,
    input  logic                            xoff2_en,
    input  logic                            rx_valid,
    input  logic [CHR_W-1:0]                rx_data,
    input  logic [NUM_CHR-1:0][CHR_W-1:0]   slot_q,
    output logic [NUM_CHR-1:0]              hit,
    output logic                            xoff_hit,
    output logic                            raise
);

    logic inband;
    assign inband = (flow_rx_sel != 2'b00);

    for (genvar i = 0; i < NUM_CHR; i++) begin : g_cmp
        logic full_eq;
        logic low_eq;
        logic hit_c;

        assign full_eq = (rx_data == slot_q[i]);
        assign low_eq  = (rx_data[LOW_W-1:0] == slot_q[i][LOW_W-1:0]);

        always_comb begin
            hit_c = 1'b0;
            unique case (mode)
                DM_NINE: hit_c = full_eq;
                DM_ENH: begin
                    if (i == XOFF1_IDX)      hit_c = spc_en && inband && low_eq;
                    else if (i == XOFF2_IDX) hit_c = spc_en && xoff2_en && low_eq;
                    else                     hit_c = 1'b0;
                end
                DM_ALT750: hit_c = 1'b0;
                DM_NONE:   hit_c = 1'b0;
            endcase
        end

        assign hit[i] = rx_valid && hit_c;
    end

    // flow-control path is independent of the special-character enable
    assign xoff_hit = rx_valid && (mode == DM_ENH) && inband &&
                      (rx_data[LOW_W-1:0] == slot_q[XOFF1_IDX][LOW_W-1:0]);

    // in enhanced mode every hit already carries spc_en
    assign raise = spc_en && (hit != '0);

endmodule

// File: rtl/spchr_irq_fsm.sv
module spchr_irq_fsm
    import spchr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic clr,
    output logic irq
);

    irq_st_e state_q;
    irq_st_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: state_d = raise ? IRQ_PEND : IRQ_IDLE;
            IRQ_PEND: state_d = (clr && !raise) ? IRQ_IDLE : IRQ_PEND;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_PEND);
    end

endmodule

// File: rtl/spchr_detect.sv
module spchr_detect
    import spchr_pkg::*;
#(
    parameter int CHR_W     = 9,
    parameter int NUM_CHR   = 4,
    parameter int XOFF1_IDX = 2,
    parameter int XOFF2_IDX = 3,
    localparam int IDX_W    = (NUM_CHR > 1) ? $clog2(NUM_CHR) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic [IDX_W-1:0]   cfg_wr_idx,
    input  logic [CHR_W-1:0]   cfg_wr_data,
    input  logic               rx_valid,
    input  logic [CHR_W-1:0]   rx_data,
    input  logic               mode_nine,
    input  logic               mode_alt750,
    input  logic               mode_enh,
    input  logic [1:0]         flow_rx_sel,
    input  logic               xoff2_en,
    input  logic               spc_int_en,
    input  logic               stat_clr,
    output logic [NUM_CHR-1:0] match_flags,
    output logic               xoff_det,
    output logic               spc_irq
);

    logic [NUM_CHR-1:0][CHR_W-1:0] slot_q;
    logic [NUM_CHR-1:0]            hit;
    logic                          xoff_hit;
    logic                          raise;
    det_mode_e                     mode;
    logic [NUM_CHR-1:0]            flags_q;
    logic                          xoff_q;

    assign mode = decode_mode(mode_nine, mode_alt750, mode_enh);

    spchr_regs #(.CHR_W(CHR_W), .NUM_CHR(NUM_CHR)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_idx  (cfg_wr_idx),
        .wr_data (cfg_wr_data),
        .slot_q  (slot_q)
    );

    spchr_match #(
        .CHR_W(CHR_W), .NUM_CHR(NUM_CHR),
        .XOFF1_IDX(XOFF1_IDX), .XOFF2_IDX(XOFF2_IDX)
    ) u_match (
        .mode        (mode),
        .spc_en      (spc_int_en),
        .flow_rx_sel (flow_rx_sel),
        .xoff2_en    (xoff2_en),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .slot_q      (slot_q),
        .hit         (hit),
        .xoff_hit    (xoff_hit),
        .raise       (raise)
    );

    spchr_irq_fsm u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (raise),
        .clr   (stat_clr),
        .irq   (spc_irq)
    );

    // new hits take priority over a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            xoff_q  <= 1'b0;
        end else begin
            flags_q <= (stat_clr ? '0 : flags_q) | hit;
            xoff_q  <= xoff_hit;
        end
    end

    assign match_flags = flags_q;
    assign xoff_det    = xoff_q;

endmodule

// File: rtl/spchr_chk.sv
module spchr_chk #(
    parameter int NUM_CHR = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rx_valid,
    input logic               mode_nine,
    input logic               mode_alt750,
    input logic               mode_enh,
    input logic               spc_int_en,
    input logic               stat_clr,
    input logic [NUM_CHR-1:0] match_flags,
    input logic               xoff_det,
    input logic               spc_irq
);

    p_irq_has_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        spc_irq |-> (match_flags != '0));

    p_xoff_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xoff_det |-> ($past(rx_valid) && $past(mode_enh) &&
                      !$past(mode_nine) && !$past(mode_alt750)));

    p_alt750_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mode_alt750 && !mode_nine && !stat_clr) |=>
        ((match_flags == $past(match_flags)) && !xoff_det));

    p_enh_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mode_enh && !mode_nine && !mode_alt750 && !spc_int_en && !stat_clr) |=>
        ((match_flags == $past(match_flags)) && (spc_irq == $past(spc_irq))));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !rx_valid) |=> ((match_flags == '0) && !spc_irq));

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_clr && !rx_valid) |=>
        ((match_flags == $past(match_flags)) && (spc_irq == $past(spc_irq))));

    p_plain_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !mode_nine && !mode_alt750 && !mode_enh && !stat_clr) |=>
        ((match_flags == $past(match_flags)) && !xoff_det));

endmodule

bind spchr_detect spchr_chk #(.NUM_CHR(NUM_CHR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .mode_nine   (mode_nine),
    .mode_alt750 (mode_alt750),
    .mode_enh    (mode_enh),
    .spc_int_en  (spc_int_en),
    .stat_clr    (stat_clr),
    .match_flags (match_flags),
    .xoff_det    (xoff_det),
    .spc_irq     (spc_irq)
);

// File: tb/tb_spchr_detect.sv
module tb_spchr_detect;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [1:0] cfg_wr_idx = '0;
    logic [8:0] cfg_wr_data = '0;
    logic       rx_valid = 1'b0;
    logic [8:0] rx_data = '0;
    logic       mode_nine = 1'b0, mode_alt750 = 1'b0, mode_enh = 1'b0;
    logic [1:0] flow_rx_sel = '0;
    logic       xoff2_en = 1'b0, spc_int_en = 1'b0, stat_clr = 1'b0;
    logic [3:0] match_flags;
    logic       xoff_det, spc_irq;

    // configuration staged here, applied at the next driven edge
    logic       c_nine = 0, c_alt = 0, c_enh = 0, c_x2 = 0, c_ien = 0;
    logic [1:0] c_flow = '0;

    logic [8:0] m_slot [4];
    logic [3:0] m_flags = '0;
    logic       m_irq = 1'b0;

    typedef struct {
        logic [3:0] f;
        logic       i;
        logic       x;
        string      tag;
    } exp_t;
    exp_t sb[$];

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #10 clk = ~clk;

    spchr_detect dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .mode_nine(mode_nine), .mode_alt750(mode_alt750), .mode_enh(mode_enh),
        .flow_rx_sel(flow_rx_sel), .xoff2_en(xoff2_en),
        .spc_int_en(spc_int_en), .stat_clr(stat_clr),
        .match_flags(match_flags), .xoff_det(xoff_det), .spc_irq(spc_irq)
    );

    task automatic drive(input logic v, input logic [8:0] d, input logic clr,
                         input logic we, input logic [1:0] wi, input logic [8:0] wd,
                         input string tag);
        logic [3:0] hits;
        logic       x;
        logic       gate;
        @(negedge clk);
        mode_nine = c_nine; mode_alt750 = c_alt; mode_enh = c_enh;
        flow_rx_sel = c_flow; xoff2_en = c_x2; spc_int_en = c_ien;
        rx_valid = v; rx_data = d; stat_clr = clr;
        cfg_wr_en = we; cfg_wr_idx = wi; cfg_wr_data = wd;
        hits = '0; x = 1'b0; gate = 1'b0;
        if (c_nine) begin
            for (int k = 0; k < 4; k++) hits[k] = (d == m_slot[k]);
            gate = c_ien;
        end else if (!c_alt && c_enh) begin
            if (c_ien && c_flow != 2'b00 && d[7:0] == m_slot[2][7:0]) hits[2] = 1'b1;
            if (c_ien && c_x2 && d[7:0] == m_slot[3][7:0]) hits[3] = 1'b1;
            gate = c_ien;
            x = (c_flow != 2'b00) && (d[7:0] == m_slot[2][7:0]);
        end
        if (!v) begin hits = '0; x = 1'b0; end
        m_flags = (clr ? 4'b0 : m_flags) | hits;
        m_irq   = (clr ? 1'b0 : m_irq) | ((hits != '0) && gate);
        if (we) m_slot[wi] = wd;
        sb.push_back('{f: m_flags, i: m_irq, x: x, tag: tag});
    endtask

    task automatic rx(input logic [8:0] d, input string tag);
        drive(1'b1, d, 1'b0, 1'b0, 2'd0, 9'd0, tag);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, 9'd0, 1'b0, 1'b0, 2'd0, 9'd0, tag);
    endtask

    task automatic clr(input string tag);
        drive(1'b0, 9'd0, 1'b1, 1'b0, 2'd0, 9'd0, tag);
    endtask

    task automatic wr(input logic [1:0] i, input logic [8:0] d, input string tag);
        drive(1'b0, 9'd0, 1'b0, 1'b1, i, d, tag);
    endtask

    // monitor: compares each result 2 ns after the edge that produced it
    always @(posedge clk) begin
        #2;
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            compared++;
            if (match_flags !== e.f || spc_irq !== e.i || xoff_det !== e.x) begin
                mismatched++;
                $display("FAIL %s: flags=%b exp %b, irq=%b exp %b, xoff=%b exp %b",
                         e.tag, match_flags, e.f, spc_irq, e.i, xoff_det, e.x);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) m_slot[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        compared++;
        if (match_flags !== 4'b0 || spc_irq !== 1'b0 || xoff_det !== 1'b0) begin
            mismatched++;
            $display("FAIL R1 reset: flags=%b irq=%b xoff=%b exp 0000 0 0",
                     match_flags, spc_irq, xoff_det);
        end

        // 9-bit mode, slots still zero
        c_nine = 1; c_ien = 0;
        rx(9'h000, "R1 zero slots all match");
        clr("R9 clear");
        wr(2'd0, 9'h155, "R11 write slot0");
        wr(2'd1, 9'h055, "R11 write slot1");
        wr(2'd2, 9'h013, "R11 write slot2");
        wr(2'd3, 9'h1A0, "R11 write slot3");
        rx(9'h155, "R2 slot0 with address bit, R3 no irq when disabled");
        rx(9'h055, "R2 slot1, bit 8 differs from slot0");
        rx(9'h113, "R2 bit 8 mismatch on slot2");
        clr("R9 clear");
        c_ien = 1;
        rx(9'h1A0, "R3 slot3 raises irq");
        idle("R9 sticky");
        idle("R9 sticky");
        drive(1'b1, 9'h013, 1'b1, 1'b0, 2'd0, 9'd0, "R9 match beats clear");
        clr("R9 clear");
        idle("R9 cleared stays low");
        rx(9'h155, "R10 irq re-raised after clear");
        clr("R9 clear");
        drive(1'b1, 9'h155, 1'b0, 1'b1, 2'd0, 9'h0AA, "R11 write with strobe uses old value");
        clr("R9 clear");
        rx(9'h155, "R11 old value no longer matches");
        rx(9'h0AA, "R11 new value matches");
        clr("R9 clear");

        // enhanced mode
        c_nine = 0; c_enh = 1; c_ien = 0; c_flow = 2'b10; c_x2 = 1;
        rx(9'h013, "R4 no flag with enable clear, R8 xoff pulse anyway");
        idle("R8 pulse lasts one cycle");
        rx(9'h0A0, "R4 xoff2 ignored with enable clear");
        c_ien = 1;
        rx(9'h113, "R5 xoff1 match ignores bit 8, R8 pulse");
        rx(9'h013, "R8 back-to-back xoff pulse");
        clr("R9 clear");
        c_flow = 2'b00;
        rx(9'h013, "R5 no xoff detection without in-band flow control");
        rx(9'h0A0, "R6 xoff2 match when enabled");
        clr("R9 clear");
        c_x2 = 0; c_flow = 2'b01;
        rx(9'h0A0, "R6 xoff2 ignored when disabled");
        rx(9'h0AA, "R5 slot0 unused in enhanced mode");
        rx(9'h055, "R5 slot1 unused in enhanced mode");

        // alternative 750-style mode
        c_alt = 1; c_x2 = 1;
        rx(9'h013, "R7 no detection in alternative mode");
        rx(9'h0A0, "R7 no detection in alternative mode");

        // plain mode
        c_alt = 0; c_enh = 0;
        rx(9'h013, "R12 no detection in plain mode");
        rx(9'h0A0, "R12 no detection in plain mode");
        idle("R12 idle");

        @(negedge clk); @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule